// File: doc/BRIEF.md
# Prioritized Masked Interrupt Controller

This block collects eight external interrupt request lines, which are active low, and raises a single request to a CPU core. Each line has its own mode bit. In level mode a request exists for as long as the line is held low. In edge mode a falling edge sets a sticky pending flag. Each line also has a 4-bit priority. Among the lines that are requesting, the block picks the one with the highest priority and compares that priority with the CPU's current 4-bit mask. The request goes out only if the priority is strictly above the mask.

When a request is accepted, the block raises `int_req` and pulls the active-low pin `irq_out_n` low. It presents the accepted priority on `acc_level`, so that the CPU can copy it into its mask, and the source number on `acc_vector`. The CPU pulses `int_ack` for one cycle when it swaps its next instruction for exception handling. That pulse clears the pending flag of the accepted edge-mode source. When another request still beats the mask after the clear, the pin stays low and the outputs move to that request.

Configuration is held in a small register file. Software reaches it through a single-cycle write strobe and a combinational read port. No part of the block carries a data stream, so there is no valid/ready interface. The `int_req`/`int_ack` pair is a plain level-and-pulse control pair, with no back-pressure.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, every mode bit and every priority reads 0, `int_req` is 0, `irq_out_n` is 1, and all register addresses read 0.
- R2: Register map for a 16-bit write and read at `reg_addr`:
  - Address 0: bit i is the mode bit of IRQ i (0 = level-low, 1 = falling edge).
  - Address 1: bits [4i+3:4i] hold the priority of IRQ i, for i = 0..3.
  - Address 2: the same field layout for IRQ 4..7.
  - Address 3 reads 0, and writes to it change nothing.
- R3: A source with priority 0 never produces a request. The same source produces one once it is given a non-zero priority.
- R4: Among the requesting sources, the one with the highest priority is presented. Equal priorities are resolved in favour of the lower source number.
- R5: A request is raised (`int_req`=1, `irq_out_n`=0) only when the selected priority is strictly greater than `cpu_mask`. An equal or lower priority is ignored.
- R6: In level mode a request follows the input after a two-flop synchronizer, so it is visible two clock edges after the input falls. An acknowledge does not stop a line that is still low from being raised again. The pin returns high two edges after the line goes high.
- R7: In edge mode a falling edge of the synchronized input latches a pending request. The request appears three edges after the input falls and persists after the line returns high. It is cleared on the edge at which `int_ack` is sampled while that source is the one accepted.
- R8: If another source above the mask is pending when the accepted source is acknowledged, `irq_out_n` stays low and the outputs switch to that source.
- R9: Writing a source's mode bit to 0 discards its edge latch. Setting the bit back to 1 does not restore it.
- R10: An `int_ack` sampled while `int_req` is 0 clears no pending latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n_i | input | 8 | External request lines, active low, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| cpu_mask | input | 4 | CPU current interrupt mask level |
| int_ack | input | 1 | One-cycle pulse: CPU has begun exception handling |
| int_req | output | 1 | Request to the CPU |
| irq_out_n | output | 1 | Active-low request-out pin |
| acc_level | output | 4 | Priority of the presented request, valid while int_req is 1 |
| acc_vector | output | 3 | Source number of the presented request, valid while int_req is 1 |

## Verification
The bench probes several boundary cases:
- A priority exactly equal to the mask. A design using greater-or-equal would raise a request there.
- Two sources of equal priority. Reversed tie-breaking would present IRQ5 instead of IRQ3.
- An acknowledge while a second, higher edge request is pending. A design that released the pin on every acknowledge would show `irq_out_n` high with work still waiting. A design that cleared all latches would lose IRQ2.

Further cases follow the edge latch. It is checked to survive an acknowledge made while masked. It is checked to vanish on a switch to level mode. Its three-edge latency is checked against the two-edge latency of level mode, so an extra or a missing register stage shows up.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic {
    SENSE_LOW  = 1'b0,
    SENSE_FALL = 1'b1
  } sense_e;

  function automatic int words_for(input int items, input int per_word);
    return (items + per_word - 1) / per_word;
  endfunction
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs #(
  parameter int N_SRC  = 8,
  parameter int LVL_W  = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      rdata,
  output logic [N_SRC-1:0]       sense,
  output logic [N_SRC*LVL_W-1:0] lvl
);
  localparam int PER_WORD = DATA_W / LVL_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense <= '0;
    end else if (we && addr == '0) begin
      sense <= wdata[N_SRC-1:0];
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_lvl
    localparam int WORD = i / PER_WORD + 1;
    localparam int POS  = (i % PER_WORD) * LVL_W;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl[i*LVL_W +: LVL_W] <= '0;
      end else if (we && addr == ADDR_W'(WORD)) begin
        lvl[i*LVL_W +: LVL_W] <= wdata[POS +: LVL_W];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == '0) rdata[N_SRC-1:0] = sense;
    for (int i = 0; i < N_SRC; i++) begin
      if (addr == ADDR_W'(i / PER_WORD + 1))
        rdata[(i % PER_WORD)*LVL_W +: LVL_W] = lvl[i*LVL_W +: LVL_W];
    end
  end
endmodule

// File: rtl/irqc_src.sv
module irqc_src
  import irqc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_n,
  input  logic sense,
  input  logic ack_hit,
  output logic pending
);
  logic [SYNC_STAGES-1:0] sh;
  logic s, prev, fall, latch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[SYNC_STAGES-2:0], irq_n};
  end
  assign s = sh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= s;
  end
  assign fall = prev & ~s;

  // A new edge wins over a simultaneous acknowledge, so no edge is lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    latch <= 1'b0;
    else if (sense == SENSE_LOW)   latch <= 1'b0;
    else if (fall)                 latch <= 1'b1;
    else if (ack_hit)              latch <= 1'b0;
  end

  assign pending = (sense == SENSE_FALL) ? latch : ~s;

  a_r7_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sense && latch && !ack_hit) |=> latch);
  a_r7_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    (sense && !latch && !fall) |=> !latch);
  a_r9_mode_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !sense |=> !latch);
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 4,
  parameter int VEC_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SRC-1:0]       req,
  input  logic [N_SRC*LVL_W-1:0] lvl,
  output logic                   any,
  output logic [LVL_W-1:0]       best_lvl,
  output logic [VEC_W-1:0]       best_idx
);
  logic [N_SRC-1:0] elig;

  for (genvar i = 0; i < N_SRC; i++) begin : g_elig
    assign elig[i] = req[i] && (lvl[i*LVL_W +: LVL_W] != '0);
  end

  // Ascending scan with a strict compare: the lower index keeps a tie.
  always_comb begin
    any      = 1'b0;
    best_lvl = '0;
    best_idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (!any || lvl[i*LVL_W +: LVL_W] > best_lvl)) begin
        any      = 1'b1;
        best_lvl = lvl[i*LVL_W +: LVL_W];
        best_idx = VEC_W'(i);
      end
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_chk
    a_r4_none_higher: assert property (@(posedge clk) disable iff (!rst_n)
      elig[i] |-> (any && lvl[i*LVL_W +: LVL_W] <= best_lvl));
    a_r4_tie_low_index: assert property (@(posedge clk) disable iff (!rst_n)
      (elig[i] && lvl[i*LVL_W +: LVL_W] == best_lvl) |-> (VEC_W'(i) >= best_idx));
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int N_SRC       = 8,
  parameter int LVL_W       = 4,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = $clog2(irqc_pkg::words_for(N_SRC, DATA_W / LVL_W) + 1),
  parameter int VEC_W       = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_n_i,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [LVL_W-1:0]  cpu_mask,
  input  logic              int_ack,
  output logic              int_req,
  output logic              irq_out_n,
  output logic [LVL_W-1:0]  acc_level,
  output logic [VEC_W-1:0]  acc_vector
);
  logic [N_SRC-1:0]       sense, pending, ack_hit;
  logic [N_SRC*LVL_W-1:0] lvl;
  logic                   any;

  irqc_regs #(.N_SRC(N_SRC), .LVL_W(LVL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .sense(sense), .lvl(lvl)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign ack_hit[i] = int_ack && int_req && (acc_vector == VEC_W'(i));
    irqc_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
      .clk(clk), .rst_n(rst_n), .irq_n(irq_n_i[i]), .sense(sense[i]),
      .ack_hit(ack_hit[i]), .pending(pending[i])
    );
  end

  irqc_arb #(.N_SRC(N_SRC), .LVL_W(LVL_W), .VEC_W(VEC_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(pending), .lvl(lvl),
    .any(any), .best_lvl(acc_level), .best_idx(acc_vector)
  );

  assign int_req   = any && (acc_level > cpu_mask);
  assign irq_out_n = ~int_req;

  a_r5_strict_mask: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (acc_level > cpu_mask));
  a_r3_zero_never_wins: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (acc_level != '0));
  a_r5_selected_pending: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> pending[acc_vector]);
  a_r10_ack_only_target: assert property (@(posedge clk) disable iff (!rst_n)
    !int_req |-> (ack_hit == '0));
endmodule

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_n_i = 8'hFF;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [3:0]  cpu_mask = '0;
  logic        int_ack = 1'b0;
  logic        int_req, irq_out_n;
  logic [3:0]  acc_level;
  logic [2:0]  acc_vector;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_n_i(irq_n_i), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_mask(cpu_mask), .int_ack(int_ack),
    .int_req(int_req), .irq_out_n(irq_out_n), .acc_level(acc_level), .acc_vector(acc_vector)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic ack();
    @(negedge clk);
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
    #1;
  endtask

  task automatic pulse(input int i);
    irq_n_i[i] = 1'b0;
    step(3);
    irq_n_i[i] = 1'b1;
    step(4);
  endtask

  task automatic clean();
    irq_n_i = 8'hFF; cpu_mask = '0;
    wr(2'd0, 16'h0000); wr(2'd1, 16'h0000); wr(2'd2, 16'h0000);
    step(4);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1", "int_req", int_req, 0);
    chk("R1", "irq_out_n", irq_out_n, 1);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1", "rdata", d, 0);
    end
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr(2'd0, 16'h00A5); rd(2'd0, d); chk("R2", "sense reg", d, 16'h00A5);
    wr(2'd1, 16'h4321); rd(2'd1, d); chk("R2", "level lo", d, 16'h4321);
    wr(2'd2, 16'h8765); rd(2'd2, d); chk("R2", "level hi", d, 16'h8765);
    wr(2'd3, 16'hFFFF); rd(2'd3, d); chk("R2", "addr3", d, 0);
    rd(2'd0, d); chk("R2", "sense after addr3 write", d, 16'h00A5);
    rd(2'd1, d); chk("R2", "level lo after addr3 write", d, 16'h4321);
    clean();
  endtask

  task automatic t_disabled();
    irq_n_i[3] = 1'b0;
    step(5);
    chk("R3", "req at level 0", int_req, 0);
    wr(2'd1, 16'h1000);
    chk("R3", "req at level 1", int_req, 1);
    chk("R3", "vector", acc_vector, 3);
    clean();
  endtask

  task automatic t_prio();
    wr(2'd1, 16'h6000); wr(2'd2, 16'h00A0);
    irq_n_i[3] = 1'b0; irq_n_i[5] = 1'b0;
    step(5);
    chk("R4", "highest vector", acc_vector, 5);
    chk("R4", "highest level", acc_level, 10);
    wr(2'd1, 16'hA000);
    chk("R4", "tie vector", acc_vector, 3);
    chk("R4", "tie level", acc_level, 10);
    cpu_mask = 4'd10;
    step(1);
    chk("R5", "equal mask int_req", int_req, 0);
    chk("R5", "equal mask pin", irq_out_n, 1);
    cpu_mask = 4'd9;
    step(1);
    chk("R5", "mask below int_req", int_req, 1);
    chk("R5", "mask below pin", irq_out_n, 0);
    clean();
  endtask

  task automatic t_level();
    wr(2'd1, 16'h0070);
    irq_n_i[1] = 1'b0;
    step(1);
    chk("R6", "one edge after fall", int_req, 0);
    step(1);
    chk("R6", "two edges after fall", int_req, 1);
    ack();
    chk("R6", "still low after ack", irq_out_n, 0);
    irq_n_i[1] = 1'b1;
    step(1);
    chk("R6", "one edge after rise", irq_out_n, 0);
    step(1);
    chk("R6", "released", irq_out_n, 1);
    clean();
  endtask

  task automatic t_edge();
    wr(2'd0, 16'h0004); wr(2'd1, 16'h0500);
    irq_n_i[2] = 1'b0;
    step(2);
    chk("R7", "two edges after fall", int_req, 0);
    step(1);
    chk("R7", "three edges after fall", int_req, 1);
    irq_n_i[2] = 1'b1;
    step(4);
    chk("R7", "latched after rise", irq_out_n, 0);
    ack();
    chk("R7", "pin after ack", irq_out_n, 1);
    step(3);
    chk("R7", "stays clear", int_req, 0);
    clean();
  endtask

  task automatic t_higher();
    wr(2'd0, 16'h0006); wr(2'd1, 16'h0590);
    pulse(2);
    chk("R8", "first vector", acc_vector, 2);
    pulse(1);
    chk("R8", "higher vector", acc_vector, 1);
    chk("R8", "higher level", acc_level, 9);
    ack();
    chk("R8", "pin low after ack", irq_out_n, 0);
    chk("R8", "next vector", acc_vector, 2);
    chk("R8", "next level", acc_level, 5);
    ack();
    chk("R8", "pin high after second ack", irq_out_n, 1);
    clean();
  endtask

  task automatic t_masked_ack();
    wr(2'd0, 16'h0004); wr(2'd1, 16'h0500);
    cpu_mask = 4'd5;
    pulse(2);
    chk("R10", "masked", int_req, 0);
    ack();
    cpu_mask = 4'd0;
    step(1);
    chk("R10", "latch survived", int_req, 1);
    chk("R10", "vector", acc_vector, 2);
    clean();
  endtask

  task automatic t_mode();
    wr(2'd0, 16'h0004); wr(2'd1, 16'h0500);
    pulse(2);
    chk("R9", "pending before switch", int_req, 1);
    wr(2'd0, 16'h0000);
    chk("R9", "level mode, input high", int_req, 0);
    wr(2'd0, 16'h0004);
    step(2);
    chk("R9", "latch not restored", int_req, 0);
    clean();
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_regs();
    t_disabled();
    t_prio();
    t_level();
    t_edge();
    t_higher();
    t_masked_ack();
    t_mode();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule